// File: doc/BRIEF.md
# Ethernet Power-Down and Wake Sequencer

This block carries out, for the host, the ordered shutdown and restart of an Ethernet controller's subsystems. It acts as the master of a simple register bus (address, write data, write strobe, read strobe, read data) that reaches the controller's register file. The host gives a one-cycle `sleep_req` or `wake_req` pulse. The sequencer then works through a fixed list of steps, one at a time, and reports `busy`, `asleep`, a one-cycle `done` and an `error` flag.

Every step is one of two kinds. A modify step reads a register, changes only the selected bits and writes the word back. A poll step reads a status bit again and again until it reads zero. Going to sleep, the sequencer turns off the crypto engines and receive enable. It then waits for receive activity to end, then for any pending transmit request to clear. After that it puts the PHY to sleep and, as the last step, clears the core enable and the LED pulse-stretch enable in a single write. Waking runs three modify steps in the opposite sense. The PHY loses its configuration while asleep, so a completed wake raises `reconfig_needed` for the host.

The state machine has five states. ST_IDLE accepts requests. ST_READ issues a read. ST_CAPTURE takes the read data: a poll step then advances, re-polls or times out, and a modify step goes on to ST_WRITE. ST_WRITE writes the modified word. ST_FINISH pulses `done` and returns to ST_IDLE. The transitions are: ST_IDLE to ST_READ on an accepted request. ST_READ to ST_CAPTURE always. ST_CAPTURE to ST_READ on a busy poll that is still under its limit. ST_CAPTURE to ST_IDLE on a poll timeout. ST_CAPTURE to ST_WRITE on a modify step. ST_CAPTURE or ST_WRITE to ST_READ when a step completes and is not the last one. ST_CAPTURE or ST_WRITE to ST_FINISH when the last step completes. ST_FINISH to ST_IDLE always.

Top module: `eth_pwr_seq`

## Requirements
- R1: After reset, `busy`, `asleep`, `done`, `error` and `reconfig_needed` are 0, and neither `bus_we` nor `bus_re` is asserted.
- R2: A sleep sequence writes its registers in this order: crypto register (crypto enable bit B_CRYPTO cleared), control register (receive enable bit B_RXEN cleared), PHY register (sleep bit B_SLEEP set), core register. Exactly four writes take place.
- R3: Before the PHY write, the status register is read repeatedly until its receive-busy bit B_RXBUSY reads 0. This takes one read per busy result plus one final read that returns 0, and all of these reads come before the transmit poll starts.
- R4: After the receive drain, the control register is read repeatedly until its transmit-request bit B_TXREQ reads 0. This takes one read per set result plus one final read that returns 0.
- R5: Every write is a read-modify-write of the word read from the same address in the cycle before. Only the target bits change, and the core enable B_CORE and the LED stretch enable B_LED are changed together in a single write.
- R6: A wake sequence writes in this order: core register (B_CORE and B_LED set), PHY register (B_SLEEP cleared), control register (B_RXEN set). Exactly three writes take place.
- R7: `done` is high for exactly one cycle at the end of each completed sequence. `asleep` rises in the cycle after the `done` of a sleep sequence and falls in the cycle after the `done` of a wake sequence.
- R8: `reconfig_needed` rises in the cycle after the `done` of a wake sequence. It is cleared when the next sleep request is accepted.
- R9: A `sleep_req` is ignored while `busy` or `asleep` is 1. A `wake_req` is ignored while `busy` is 1 or `asleep` is 0. An ignored request causes no bus access and does not change `asleep`.
- R10: Within one poll step, the read that returns the busy value for the `poll_limit`-th time ends the sequence: `error` goes to 1 and the sequencer returns to idle with `asleep` 0. No `done` pulse is given, and no PHY or core write is made. A `poll_limit` of 0 acts as 1.
- R11: `error` stays set until the next request is accepted, and it is cleared at that point.
- R12: Read data is taken one cycle after `bus_re`, and `bus_we` and `bus_re` are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | One-cycle pulse that starts the shutdown sequence |
| wake_req | input | 1 | One-cycle pulse that starts the wake sequence |
| poll_limit | input | TO_W | Number of busy poll reads that causes a timeout |
| bus_addr | output | AW | Register bus address |
| bus_wdata | output | DW | Register bus write data |
| bus_we | output | 1 | Register bus write strobe |
| bus_re | output | 1 | Register bus read strobe |
| bus_rdata | input | DW | Register bus read data, valid the cycle after `bus_re` |
| busy | output | 1 | A sequence is running |
| asleep | output | 1 | The controller has been shut down |
| done | output | 1 | One-cycle pulse when a sequence completes |
| error | output | 1 | The last sequence ended on a poll timeout |
| reconfig_needed | output | 1 | The PHY must be configured again after wake |

## Verification
The bench builds the sequencer with an 8-bit timeout counter and moves every register to a new address. It places the crypto enable and the LED stretch enable on bit 15, which is the top of the word, and the core enable on bit 0, so both edges of the data word are exercised. The core enable and the LED stretch enable also sit far apart in the same register. The small `poll_limit` values (0 to 6) make both timeout paths quick to reach. The runs include a poll that turns idle on its last allowed read, and the read that hits the limit exactly.

// File: rtl/eth_pwr_pkg.sv
package eth_pwr_pkg;

    parameter int unsigned STEP_IDX_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_CAPTURE,
        ST_WRITE,
        ST_FINISH
    } seq_state_t;

    typedef enum logic {
        DIR_SLEEP,
        DIR_WAKE
    } seq_dir_t;

    typedef enum logic {
        OP_MODIFY,
        OP_POLL
    } op_kind_t;

endpackage

// File: rtl/eth_pwr_steps.sv
module eth_pwr_steps
    import eth_pwr_pkg::*;
#(
    parameter int unsigned AW = 8,
    parameter int unsigned DW = 16,
    parameter logic [AW-1:0] A_CRYPTO = 'h30,
    parameter logic [AW-1:0] A_CTRL   = 'h31,
    parameter logic [AW-1:0] A_STAT   = 'h32,
    parameter logic [AW-1:0] A_PHY    = 'h50,
    parameter logic [AW-1:0] A_CORE   = 'h33,
    parameter int unsigned B_CRYPTO = 2,
    parameter int unsigned B_RXEN   = 0,
    parameter int unsigned B_TXREQ  = 1,
    parameter int unsigned B_RXBUSY = 4,
    parameter int unsigned B_SLEEP  = 9,
    parameter int unsigned B_CORE   = 7,
    parameter int unsigned B_LED    = 6
) (
    input  seq_dir_t              dir,
    input  logic [STEP_IDX_W-1:0] idx,
    output op_kind_t              kind,
    output logic [AW-1:0]         addr,
    output logic [DW-1:0]         mask,
    output logic                  set_bits,
    output logic                  last
);

    localparam logic [DW-1:0] ONE      = {{(DW-1){1'b0}}, 1'b1};
    localparam logic [DW-1:0] M_CRYPTO = ONE << B_CRYPTO;
    localparam logic [DW-1:0] M_RXEN   = ONE << B_RXEN;
    localparam logic [DW-1:0] M_TXREQ  = ONE << B_TXREQ;
    localparam logic [DW-1:0] M_RXBUSY = ONE << B_RXBUSY;
    localparam logic [DW-1:0] M_SLEEP  = ONE << B_SLEEP;
    localparam logic [DW-1:0] M_POWER  = (ONE << B_CORE) | (ONE << B_LED);

    always_comb begin
        kind     = OP_MODIFY;
        addr     = A_CORE;
        mask     = '0;
        set_bits = 1'b0;
        last     = 1'b1;
        if (dir == DIR_SLEEP) begin
            unique case (idx)
                3'd0: begin addr = A_CRYPTO; mask = M_CRYPTO; last = 1'b0; end
                3'd1: begin addr = A_CTRL;   mask = M_RXEN;   last = 1'b0; end
                3'd2: begin kind = OP_POLL; addr = A_STAT; mask = M_RXBUSY; last = 1'b0; end
                3'd3: begin kind = OP_POLL; addr = A_CTRL; mask = M_TXREQ;  last = 1'b0; end
                3'd4: begin addr = A_PHY; mask = M_SLEEP; set_bits = 1'b1; last = 1'b0; end
                3'd5: begin addr = A_CORE; mask = M_POWER; end
                default: begin addr = A_CORE; mask = '0; end
            endcase
        end else begin
            unique case (idx)
                3'd0: begin addr = A_CORE; mask = M_POWER; set_bits = 1'b1; last = 1'b0; end
                3'd1: begin addr = A_PHY;  mask = M_SLEEP; last = 1'b0; end
                3'd2: begin addr = A_CTRL; mask = M_RXEN;  set_bits = 1'b1; end
                default: begin addr = A_CORE; mask = '0; end
            endcase
        end
    end

endmodule

// File: rtl/eth_pwr_timer.sv
module eth_pwr_timer #(
    parameter int unsigned TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            bump,
    input  logic [TO_W-1:0] limit,
    output logic            at_limit
);

    logic [TO_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (bump) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // True when one more busy read would reach the limit (limit 0 acts as 1).
    assign at_limit = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit};

endmodule

// File: rtl/eth_pwr_seq.sv
module eth_pwr_seq
    import eth_pwr_pkg::*;
#(
    parameter int unsigned AW   = 8,
    parameter int unsigned DW   = 16,
    parameter int unsigned TO_W = 16,
    parameter logic [AW-1:0] A_CRYPTO = 'h30,
    parameter logic [AW-1:0] A_CTRL   = 'h31,
    parameter logic [AW-1:0] A_STAT   = 'h32,
    parameter logic [AW-1:0] A_PHY    = 'h50,
    parameter logic [AW-1:0] A_CORE   = 'h33,
    parameter int unsigned B_CRYPTO = 2,
    parameter int unsigned B_RXEN   = 0,
    parameter int unsigned B_TXREQ  = 1,
    parameter int unsigned B_RXBUSY = 4,
    parameter int unsigned B_SLEEP  = 9,
    parameter int unsigned B_CORE   = 7,
    parameter int unsigned B_LED    = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleep_req,
    input  logic            wake_req,
    input  logic [TO_W-1:0] poll_limit,
    output logic [AW-1:0]   bus_addr,
    output logic [DW-1:0]   bus_wdata,
    output logic            bus_we,
    output logic            bus_re,
    input  logic [DW-1:0]   bus_rdata,
    output logic            busy,
    output logic            asleep,
    output logic            done,
    output logic            error,
    output logic            reconfig_needed
);

    seq_state_t            state_q, state_nx;
    seq_dir_t              dir_q;
    logic [STEP_IDX_W-1:0] idx_q;
    logic [DW-1:0]         shadow_q;
    logic                  asleep_q, error_q, reconfig_q;

    op_kind_t              st_kind;
    logic [AW-1:0]         st_addr;
    logic [DW-1:0]         st_mask;
    logic                  st_set, st_last;

    logic accept_sleep, accept_wake, step_adv, poll_fail, poll_again, tmr_at_limit;

    eth_pwr_steps #(
        .AW(AW), .DW(DW),
        .A_CRYPTO(A_CRYPTO), .A_CTRL(A_CTRL), .A_STAT(A_STAT), .A_PHY(A_PHY), .A_CORE(A_CORE),
        .B_CRYPTO(B_CRYPTO), .B_RXEN(B_RXEN), .B_TXREQ(B_TXREQ), .B_RXBUSY(B_RXBUSY),
        .B_SLEEP(B_SLEEP), .B_CORE(B_CORE), .B_LED(B_LED)
    ) u_steps (
        .dir      (dir_q),
        .idx      (idx_q),
        .kind     (st_kind),
        .addr     (st_addr),
        .mask     (st_mask),
        .set_bits (st_set),
        .last     (st_last)
    );

    eth_pwr_timer #(.TO_W(TO_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (step_adv | accept_sleep | accept_wake),
        .bump     (poll_again),
        .limit    (poll_limit),
        .at_limit (tmr_at_limit)
    );

    // Next-state and step control.
    always_comb begin
        state_nx     = state_q;
        accept_sleep = 1'b0;
        accept_wake  = 1'b0;
        step_adv     = 1'b0;
        poll_fail    = 1'b0;
        poll_again   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (sleep_req && !asleep_q) begin
                    accept_sleep = 1'b1;
                    state_nx     = ST_READ;
                end else if (wake_req && asleep_q) begin
                    accept_wake = 1'b1;
                    state_nx    = ST_READ;
                end
            end
            ST_READ: state_nx = ST_CAPTURE;
            ST_CAPTURE: begin
                if (st_kind == OP_POLL) begin
                    if ((bus_rdata & st_mask) == '0) begin
                        step_adv = 1'b1;
                    end else if (tmr_at_limit) begin
                        poll_fail = 1'b1;
                        state_nx  = ST_IDLE;
                    end else begin
                        poll_again = 1'b1;
                        state_nx   = ST_READ;
                    end
                end else begin
                    state_nx = ST_WRITE;
                end
            end
            ST_WRITE:  step_adv = 1'b1;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
        if (step_adv) begin
            state_nx = st_last ? ST_FINISH : ST_READ;
        end
    end

    // State register and sequence bookkeeping.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            dir_q      <= DIR_SLEEP;
            idx_q      <= '0;
            shadow_q   <= '0;
            asleep_q   <= 1'b0;
            error_q    <= 1'b0;
            reconfig_q <= 1'b0;
        end else begin
            state_q <= state_nx;
            if (accept_sleep) begin
                dir_q      <= DIR_SLEEP;
                idx_q      <= '0;
                error_q    <= 1'b0;
                reconfig_q <= 1'b0;
            end
            if (accept_wake) begin
                dir_q   <= DIR_WAKE;
                idx_q   <= '0;
                error_q <= 1'b0;
            end
            if (state_q == ST_CAPTURE && st_kind == OP_MODIFY) begin
                shadow_q <= bus_rdata;
            end
            if (step_adv && !st_last) begin
                idx_q <= idx_q + 1'b1;
            end
            if (poll_fail) begin
                error_q <= 1'b1;
            end
            if (state_q == ST_FINISH) begin
                if (dir_q == DIR_SLEEP) begin
                    asleep_q <= 1'b1;
                end else begin
                    asleep_q   <= 1'b0;
                    reconfig_q <= 1'b1;
                end
            end
        end
    end

    // Outputs.
    always_comb begin
        bus_re    = (state_q == ST_READ);
        bus_we    = (state_q == ST_WRITE);
        bus_addr  = (state_q == ST_IDLE || state_q == ST_FINISH) ? '0 : st_addr;
        bus_wdata = '0;
        if (state_q == ST_WRITE) begin
            bus_wdata = st_set ? (shadow_q | st_mask) : (shadow_q & ~st_mask);
        end
        busy            = (state_q != ST_IDLE);
        done            = (state_q == ST_FINISH);
        asleep          = asleep_q;
        error           = error_q;
        reconfig_needed = reconfig_q;
    end

endmodule

// File: rtl/eth_pwr_seq_chk.sv
module eth_pwr_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic sleep_req,
    input logic wake_req,
    input logic bus_we,
    input logic bus_re,
    input logic busy,
    input logic asleep,
    input logic done,
    input logic error,
    input logic reconfig_needed
);

    p_no_rw_overlap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && bus_re));

    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_asleep_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> $past(done));

    p_wake_after_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asleep) |-> $past(done));

    p_reconfig_after_wake_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(reconfig_needed) |-> ($past(done) && !asleep));

    p_wake_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !asleep && wake_req && !sleep_req) |=> !busy);

    p_sleep_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && asleep && sleep_req && !wake_req) |=> (!busy && asleep));

    p_timeout_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> (!busy && !asleep && !$past(done)));

    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!bus_we && !bus_re));

endmodule

bind eth_pwr_seq eth_pwr_seq_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .sleep_req       (sleep_req),
    .wake_req        (wake_req),
    .bus_we          (bus_we),
    .bus_re          (bus_re),
    .busy            (busy),
    .asleep          (asleep),
    .done            (done),
    .error           (error),
    .reconfig_needed (reconfig_needed)
);

// File: tb/eth_pwr_seq_tb.sv
`timescale 1ns/1ps
module eth_pwr_seq_tb;

    localparam int AW = 8;
    localparam int DW = 16;
    localparam int TO_W = 8;
    localparam logic [7:0] A_CRY = 8'h04, A_CTL = 8'h08, A_STA = 8'h0C, A_PHY = 8'h40, A_COR = 8'h1F;
    localparam int B_CRY = 15, B_RX = 0, B_TX = 7, B_BSY = 3, B_SLP = 10, B_COR = 0, B_LED = 15;
    localparam logic [15:0] M_CRY = 16'h1 << B_CRY;
    localparam logic [15:0] M_RX  = 16'h1 << B_RX;
    localparam logic [15:0] M_TX  = 16'h1 << B_TX;
    localparam logic [15:0] M_SLP = 16'h1 << B_SLP;
    localparam logic [15:0] M_PWR = (16'h1 << B_COR) | (16'h1 << B_LED);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_req = 1'b0, wake_req = 1'b0;
    logic [TO_W-1:0] poll_limit = 8'd4;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;
    logic bus_we, bus_re, busy, asleep, done, error, reconfig_needed;

    always #5 clk = ~clk;

    eth_pwr_seq #(
        .AW(AW), .DW(DW), .TO_W(TO_W),
        .A_CRYPTO(A_CRY), .A_CTRL(A_CTL), .A_STAT(A_STA), .A_PHY(A_PHY), .A_CORE(A_COR),
        .B_CRYPTO(B_CRY), .B_RXEN(B_RX), .B_TXREQ(B_TX), .B_RXBUSY(B_BSY),
        .B_SLEEP(B_SLP), .B_CORE(B_COR), .B_LED(B_LED)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .wake_req(wake_req),
        .poll_limit(poll_limit), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .busy(busy),
        .asleep(asleep), .done(done), .error(error), .reconfig_needed(reconfig_needed)
    );

    // Register file model, written only by this process.
    logic [15:0] r_cry, r_ctl, r_sta, r_phy, r_cor;
    logic [15:0] i_cry, i_ctl, i_sta, i_phy, i_cor;
    logic model_load = 1'b0, load_regs = 1'b0;
    int rx_cfg = 0, tx_cfg = 0;
    int rx_left, tx_left, wn, stat_reads, tx_polls, done_cnt, bad_rmw;
    bit ctl_written;
    int wlog [0:7];
    logic [15:0] rdv, wv, last_rd;
    logic [7:0] last_rd_addr;
    logic rd_prev;

    always @(posedge clk) begin
        if (bus_re) begin
            unique case (bus_addr)
                A_CRY: rdv = r_cry;
                A_CTL: begin
                    rdv = r_ctl;
                    rdv[B_TX] = (tx_left != 0);
                    if (ctl_written) begin
                        if (tx_left > 0) tx_left--;
                        tx_polls++;
                    end
                end
                A_STA: begin
                    rdv = r_sta;
                    rdv[B_BSY] = (rx_left != 0);
                    if (rx_left > 0) rx_left--;
                    stat_reads++;
                end
                A_PHY: rdv = r_phy;
                A_COR: rdv = r_cor;
                default: rdv = 16'hDEAD;
            endcase
            bus_rdata <= rdv;
            last_rd = rdv;
            last_rd_addr = bus_addr;
        end
        if (bus_we) begin
            wv = bus_wdata;
            // R5: a write must follow a read of the same address two cycles before.
            if (last_rd_addr != bus_addr || !rd_prev) bad_rmw++;
            if (bus_addr == A_CTL) begin wv[B_TX] = 1'b0; ctl_written = 1'b1; end
            unique case (bus_addr)
                A_CRY: r_cry = wv;
                A_CTL: r_ctl = wv;
                A_STA: r_sta = wv;
                A_PHY: r_phy = wv;
                A_COR: r_cor = wv;
                default: ;
            endcase
            if (wn < 8) wlog[wn] = int'(bus_addr);
            wn++;
        end
        rd_prev = bus_re | (rd_prev & !bus_we & !bus_re);
        if (done) done_cnt++;
        if (model_load) begin
            rx_left = rx_cfg; tx_left = tx_cfg; ctl_written = 1'b0;
            wn = 0; stat_reads = 0; tx_polls = 0; done_cnt = 0; bad_rmw = 0;
            rd_prev = 1'b0;
            if (load_regs) begin
                r_cry = i_cry; r_ctl = i_ctl & ~M_TX; r_sta = i_sta; r_phy = i_phy; r_cor = i_cor;
            end
        end
    end

    int checks = 0, fails = 0;
    bit wd = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic load(input int nrx, input int ntx, input bit regs);
        @(negedge clk);
        rx_cfg = nrx; tx_cfg = ntx; load_regs = regs; model_load = 1'b1;
        @(negedge clk);
        model_load = 1'b0; load_regs = 1'b0;
    endtask

    task automatic pulse(input bit slp);
        @(negedge clk);
        if (slp) sleep_req = 1'b1; else wake_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0; wake_req = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 3000) begin @(negedge clk); n++; end
        @(negedge clk);
    endtask

    function automatic logic [15:0] clr(input logic [15:0] v, input logic [15:0] m);
        return v & ~m;
    endfunction
    function automatic logic [15:0] setb(input logic [15:0] v, input logic [15:0] m);
        return v | m;
    endfunction

    task automatic check_sleep_ok(input string tag, input int nrx, input int ntx,
                                  input logic [15:0] c0, input logic [15:0] t0,
                                  input logic [15:0] p0, input logic [15:0] k0);
        chk({tag, " R2 writes"}, wn, 4);
        chk({tag, " R2 order0"}, wlog[0], int'(A_CRY));
        chk({tag, " R2 order1"}, wlog[1], int'(A_CTL));
        chk({tag, " R2 order2"}, wlog[2], int'(A_PHY));
        chk({tag, " R2 order3"}, wlog[3], int'(A_COR));
        chk({tag, " R5 crypto"}, int'(r_cry), int'(clr(c0, M_CRY)));
        chk({tag, " R5 ctrl"}, int'(r_ctl), int'(clr(t0, M_RX | M_TX)));
        chk({tag, " R5 phy"}, int'(r_phy), int'(setb(p0, M_SLP)));
        chk({tag, " R5 core"}, int'(r_cor), int'(clr(k0, M_PWR)));
        chk({tag, " R5 rmw"}, bad_rmw, 0);
        chk({tag, " R3 rx polls"}, stat_reads, nrx + 1);
        chk({tag, " R4 tx polls"}, tx_polls, ntx + 1);
        chk({tag, " R7 asleep"}, int'(asleep), 1);
        chk({tag, " R7 done"}, done_cnt, 1);
        chk({tag, " R8 reconfig"}, int'(reconfig_needed), 0);
        chk({tag, " R11 error"}, int'(error), 0);
    endtask

    task automatic do_wake(input string tag);
        logic [15:0] t0, p0, k0;
        load(0, 0, 1'b0);
        t0 = r_ctl; p0 = r_phy; k0 = r_cor;
        pulse(1'b0);
        wait_idle();
        chk({tag, " R6 writes"}, wn, 3);
        chk({tag, " R6 order0"}, wlog[0], int'(A_COR));
        chk({tag, " R6 order1"}, wlog[1], int'(A_PHY));
        chk({tag, " R6 order2"}, wlog[2], int'(A_CTL));
        chk({tag, " R6 core"}, int'(r_cor), int'(setb(k0, M_PWR)));
        chk({tag, " R5 phy"}, int'(r_phy), int'(clr(p0, M_SLP)));
        chk({tag, " R6 ctrl"}, int'(r_ctl), int'(setb(t0, M_RX)));
        chk({tag, " R5 rmw"}, bad_rmw, 0);
        chk({tag, " R7 asleep"}, int'(asleep), 0);
        chk({tag, " R7 done"}, done_cnt, 1);
        chk({tag, " R8 reconfig"}, int'(reconfig_needed), 1);
    endtask

    task automatic run_tests();
        int lim, nrx, ntx;
        // R1 reset state
        chk("R1 busy", int'(busy), 0);
        chk("R1 asleep", int'(asleep), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 error", int'(error), 0);
        chk("R1 reconfig", int'(reconfig_needed), 0);
        chk("R1 bus", int'(bus_we | bus_re), 0);

        // R9: wake while awake is ignored
        load(0, 0, 1'b1);
        pulse(1'b0);
        repeat (4) @(negedge clk);
        chk("R9 wake awake busy", int'(busy), 0);
        chk("R9 wake awake writes", wn + stat_reads, 0);
        chk("R9 wake awake asleep", int'(asleep), 0);

        // Randomized sleep/wake rounds (R2..R8, R12)
        for (int it = 0; it < 20; it++) begin
            lim = 1 + int'($urandom_range(0, 5));
            nrx = int'($urandom_range(0, 32'(lim - 1)));
            ntx = int'($urandom_range(0, 32'(lim - 1)));
            i_cry = 16'($urandom); i_ctl = 16'($urandom); i_sta = 16'($urandom);
            i_phy = 16'($urandom); i_cor = 16'($urandom);
            poll_limit = 8'(lim);
            load(nrx, ntx, 1'b1);
            pulse(1'b1);
            wait_idle();
            check_sleep_ok($sformatf("rnd%0d", it), nrx, ntx, i_cry, clr(i_ctl, M_TX), i_phy, i_cor);
            do_wake($sformatf("rnd%0d", it));
        end

        // R10: receive drain timeout exactly at the limit
        poll_limit = 8'd3;
        load(3, 0, 1'b1);
        pulse(1'b1);
        wait_idle();
        chk("R10 rx error", int'(error), 1);
        chk("R10 rx asleep", int'(asleep), 0);
        chk("R10 rx done", done_cnt, 0);
        chk("R10 rx writes", wn, 2);
        chk("R10 rx reads", stat_reads, 3);

        // R11: error clears on next accepted request; R10 transmit timeout
        load(0, 3, 1'b1);
        pulse(1'b1);
        chk("R11 cleared on accept", int'(error), 0);
        wait_idle();
        chk("R10 tx error", int'(error), 1);
        chk("R10 tx polls", tx_polls, 3);
        chk("R10 tx writes", wn, 2);

        // R10: poll_limit 0 acts as 1
        poll_limit = 8'd0;
        load(1, 0, 1'b1);
        pulse(1'b1);
        wait_idle();
        chk("R10 zero limit error", int'(error), 1);
        chk("R10 zero limit reads", stat_reads, 1);

        // Boundary: drain becomes idle on the last allowed read; R9 sleep while busy ignored
        poll_limit = 8'd5;
        load(4, 4, 1'b1);
        pulse(1'b1);
        repeat (2) @(negedge clk);
        sleep_req = 1'b1; wake_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0; wake_req = 1'b0;
        wait_idle();
        check_sleep_ok("edge", 4, 4, i_cry, clr(i_ctl, M_TX), i_phy, i_cor);

        // R9: sleep while asleep is ignored
        load(0, 0, 1'b0);
        pulse(1'b1);
        repeat (4) @(negedge clk);
        chk("R9 sleep asleep busy", int'(busy), 0);
        chk("R9 sleep asleep access", wn + stat_reads, 0);
        chk("R9 sleep asleep state", int'(asleep), 1);

        do_wake("final");
        // R8: reconfig cleared by the next accepted sleep
        load(0, 0, 1'b0);
        pulse(1'b1);
        chk("R8 reconfig cleared", int'(reconfig_needed), 0);
        wait_idle();
        chk("R7 final asleep", int'(asleep), 1);
    endtask

    initial begin
        void'($urandom(32'd2718));
        bus_rdata = '0;
        i_cry = 16'hFFFF; i_ctl = 16'hFFFF; i_sta = 16'h0; i_phy = 16'h0; i_cor = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        fork
            run_tests();
            begin
                repeat (150000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        disable fork;
        if (wd) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual expired expected finished");
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule